// File: doc/BRIEF.md
# Debounced Keypad Matrix Scanner

This block watches a switch matrix of 8 rows by 10 columns and turns confirmed key changes into a stream of events. Rows are inputs held high by pull-ups; a closed switch pulls its row low while its column is driven low. While no key is down the block sits idle with every column driven low, so any single press pulls some row down and wakes it. Once awake it scans the matrix one column at a time, starting a full pass on each sampling tick. The tick comes from a prescaler on the system clock whose default gives 25 ms at 250 MHz. A bench may shorten it.

Each switch carries two bits of history: the last raw sample and the confirmed state. A change is confirmed only when two consecutive passes agree on the new level, which rejects glitches shorter than one pass. Press latency is therefore at least one period. Release latency lies between one and two periods. Every confirmed change leaves on a valid/ready output carrying a key code and a press flag. Events come out in the order they are found: pass by pass, column ascending, then row ascending. The valid/ready rules are as follows. `ev_valid` stays high and the payload stays unchanged until the cycle in which `ev_ready` is high. If the output is still held when another change is found, the scan itself pauses, so no event is lost or reordered. After a pass in which no key is closed or pending, the block returns to idle.

Top module: `keypad_scanner`

## Requirements
- R1: After reset `ev_valid` is 0 and all column outputs are driven low (`col_n` = 0).
- R2: While scanning, exactly one column output is low at a time, and within a pass the columns step in ascending order.
- R3: A press is reported only when two consecutive passes see the key closed; a key closed during one pass only produces no event.
- R4: A release is reported only when two consecutive passes see the key open; its latency from release is between TICK_DIV and 2*TICK_DIV cycles plus a few cycles of scan offset.
- R5: The event key code `ev_key` (7 bits) equals row*10 + column + 1, so it runs from 1 to 80 and is never 0; `ev_press` is 1 for a press and 0 for a release.
- R6: Events found in the same pass leave in column-ascending order, and by ascending row within a column. Events from different passes leave in pass order.
- R7: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_key` and `ev_press` hold. Changes found during the stall are delivered afterwards, none lost.
- R8: After a pass that finds no key closed and no change pending, the scanner returns to idle with all columns low.
- R9: Successive passes start at least TICK_DIV clock cycles apart, so a press is never reported sooner than TICK_DIV cycles after it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_in | input | 8 | Row levels, pulled high, low when a closed key meets a low column |
| col_n | output | 10 | Column drives, active low |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer accepts the event this cycle |
| ev_key | output | 7 | Key code, row*10+column+1 |
| ev_press | output | 1 | 1 = press, 0 = release |

## Verification
Several properties are checked on every cycle by assertions:
- a single low column while scanning, with columns stepping upward;
- payload hold under back-pressure;
- key codes that stay in range;
- per-key confirmation, where a confirmed state may only flip to a level the previous sample already held;
- entry into idle only after a quiet pass.

Other behaviour can only be shown by the bench's scenarios: the rejection of a one-pass glitch, the latency windows, the exact event order across columns and passes, and delivery of every event after a long stall.

// File: rtl/kps_pkg.sv
`timescale 1ns/1ps
package kps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_COMMIT,
    ST_WAIT
  } scan_st_e;
endpackage

// File: rtl/kps_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the row inputs; resets to the pulled-up level.
module kps_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/kps_tick.sv
`timescale 1ns/1ps
// Sampling-period prescaler. Restarted at each pass start, saturates at DIV-1.
module kps_tick #(
  parameter int DIV = 6_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic due
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt;

  assign due = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (!due)   cnt <= cnt + 1'b1;
  end

  // R9: a restart always drops the period count back to its origin
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !due || (DIV == 1));
endmodule

// File: rtl/kps_debounce.sv
`timescale 1ns/1ps
// Per-key history: last raw sample and confirmed state for every switch.
module kps_debounce #(
  parameter int NKEY  = 80,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [IDX_W-1:0] sel,
  input  logic             closed,
  output logic             chg,
  output logic             quiet
);
  logic [NKEY-1:0] prev;
  logic [NKEY-1:0] conf;

  assign chg   = (closed == prev[sel]) && (closed != conf[sel]);
  assign quiet = ~|prev && ~|conf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      conf <= '0;
    end else if (upd) begin
      for (int k = 0; k < NKEY; k++) begin
        if (sel == IDX_W'(k)) begin
          prev[k] <= closed;
          if (closed == prev[k]) conf[k] <= closed;
        end
      end
    end
  end

  for (genvar k = 0; k < NKEY; k++) begin : g_chk
    // R3: a confirmed press needs the previous pass to have seen it closed
    assert_press_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conf[k]) |-> $past(prev[k]));
    // R4: a confirmed release needs the previous pass to have seen it open
    assert_release_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conf[k]) |-> !$past(prev[k]));
  end
endmodule

// File: rtl/keypad_scanner.sv
`timescale 1ns/1ps
module keypad_scanner
  import kps_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 10,
  parameter int TICK_DIV = 6_250_000,
  parameter int SYNC_N   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ROWS-1:0]                   row_in,
  output logic [COLS-1:0]                   col_n,
  output logic                              ev_valid,
  input  logic                              ev_ready,
  output logic [$clog2(ROWS*COLS+1)-1:0]    ev_key,
  output logic                              ev_press
);
  localparam int NKEY   = ROWS * COLS;
  localparam int KEY_W  = $clog2(NKEY + 1);
  localparam int IDX_W  = $clog2(NKEY);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int SETTLE = SYNC_N + 1;
  localparam int SW     = $clog2(SETTLE + 1);

  scan_st_e         state;
  logic [COL_W-1:0] col_idx;
  logic [ROW_W-1:0] row_idx;
  logic [SW-1:0]    settle_cnt;
  logic [ROWS-1:0]  samp;
  logic [ROWS-1:0]  row_sync;

  logic             due, quiet, chg;
  logic             start_scan, advance, load, slot_free;
  logic             last_row, last_col, any_low;
  logic [IDX_W-1:0] sel;

  kps_sync #(.W(ROWS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(row_in), .q(row_sync)
  );

  kps_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clear(start_scan), .due(due)
  );

  kps_debounce #(.NKEY(NKEY), .IDX_W(IDX_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .upd(advance), .sel(sel),
    .closed(~samp[row_idx]), .chg(chg), .quiet(quiet)
  );

  assign any_low    = ~&row_sync;
  assign sel        = IDX_W'(int'(row_idx) * COLS + int'(col_idx));
  assign last_row   = (row_idx == ROW_W'(ROWS - 1));
  assign last_col   = (col_idx == COL_W'(COLS - 1));
  assign slot_free  = !ev_valid || ev_ready;
  assign advance    = (state == ST_COMMIT) && (!chg || slot_free);
  assign load       = advance && chg;
  assign start_scan = ((state == ST_IDLE) && any_low) ||
                      ((state == ST_WAIT) && !quiet && due);

  always_comb begin
    if (state == ST_IDLE) col_n = '0;
    else                  col_n = ~(COLS'(1) << col_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      col_idx    <= '0;
      row_idx    <= '0;
      settle_cnt <= '0;
      samp       <= '1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_scan) begin
            state      <= ST_SETTLE;
            col_idx    <= '0;
            settle_cnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (settle_cnt == SW'(SETTLE - 1)) begin
            samp    <= row_sync;
            row_idx <= '0;
            state   <= ST_COMMIT;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_COMMIT: begin
          if (advance) begin
            if (!last_row) begin
              row_idx <= row_idx + 1'b1;
            end else if (!last_col) begin
              col_idx    <= col_idx + 1'b1;
              settle_cnt <= '0;
              state      <= ST_SETTLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (quiet) begin
            state <= ST_IDLE;
          end else if (start_scan) begin
            state      <= ST_SETTLE;
            col_idx    <= '0;
            settle_cnt <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_key   <= '0;
      ev_press <= 1'b0;
    end else if (load) begin
      ev_valid <= 1'b1;
      ev_key   <= KEY_W'(int'(row_idx) * COLS + int'(col_idx) + 1);
      ev_press <= ~samp[row_idx];
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end

  assert_one_column_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> ($countones(~col_n) == 1));

  assert_col_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE && $past(state) == ST_COMMIT) |->
      (col_idx == COL_W'($past(col_idx) + 1'b1)));

  assert_key_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_key >= KEY_W'(1) && ev_key <= KEY_W'(NKEY)));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_key) && $stable(ev_press)));

  assert_idle_after_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state) == ST_WAIT) |-> $past(quiet));
endmodule

// File: tb/tb_keypad_scanner.sv
`timescale 1ns/1ps
module tb_keypad_scanner;
  localparam int ROWS = 8;
  localparam int COLS = 10;
  localparam int TDIV = 300;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [ROWS-1:0] row_in;
  logic [COLS-1:0] col_n;
  logic            ev_valid;
  logic            ev_ready = 1'b1;
  logic [6:0]      ev_key;
  logic            ev_press;
  logic [COLS-1:0] keys [ROWS];

  int checks = 0, fails = 0, cyc = 0, ev_cnt = 0;
  int log_key [64];
  int log_prs [64];
  int log_t   [64];
  bit done = 0;

  keypad_scanner #(.ROWS(ROWS), .COLS(COLS), .TICK_DIV(TDIV)) dut (
    .clk(clk), .rst_n(rst_n), .row_in(row_in), .col_n(col_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_key(ev_key), .ev_press(ev_press)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_in[r] = 1'b1;
      for (int c = 0; c < COLS; c++)
        if (!col_n[c] && keys[r][c]) row_in[r] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && ev_valid && ev_ready && ev_cnt < 64) begin
      log_key[ev_cnt] = int'(ev_key);
      log_prs[ev_cnt] = int'(ev_press);
      log_t[ev_cnt]   = cyc;
      ev_cnt = ev_cnt + 1;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int idx, input int key, input int prs, input string req);
    chk(ev_cnt > idx, req, "event present", ev_cnt, idx + 1);
    if (ev_cnt > idx) begin
      chk(log_key[idx] == key, req, "event key", log_key[idx], key);
      chk(log_prs[idx] == prs, req, "event press flag", log_prs[idx], prs);
    end
  endtask

  function automatic int code(input int r, input int c);
    return r * 10 + c + 1;
  endfunction

  task automatic t_reset;
    chk(col_n == '0, "R1", "columns low after reset", int'(col_n), 0);
    chk(ev_valid == 1'b0, "R1", "no event after reset", int'(ev_valid), 0);
  endtask

  task automatic t_single;
    int n0, tp, tr, lat, ones;
    n0 = ev_cnt; tp = cyc;
    keys[2][3] = 1'b1;
    step(20);
    ones = $countones(~col_n);
    chk(ones == 1, "R2", "one column low while scanning", ones, 1);
    step(700);
    chk(ev_cnt == n0 + 1, "R3", "single press event count", ev_cnt - n0, 1);
    expect_ev(n0, code(2, 3), 1, "R5");
    lat = log_t[n0] - tp;
    chk(lat >= TDIV && lat <= 2 * TDIV + 20, "R9", "press latency", lat, TDIV);
    tr = cyc;
    keys[2][3] = 1'b0;
    step(800);
    chk(ev_cnt == n0 + 2, "R4", "release event count", ev_cnt - n0, 2);
    expect_ev(n0 + 1, code(2, 3), 0, "R4");
    lat = log_t[n0 + 1] - tr;
    chk(lat >= TDIV && lat <= 2 * TDIV + 20, "R4", "release latency", lat, TDIV);
    chk(col_n == '0, "R8", "idle after release", int'(col_n), 0);
  endtask

  task automatic t_glitch;
    int n0;
    n0 = ev_cnt;
    keys[4][6] = 1'b1;
    step(150);
    keys[4][6] = 1'b0;
    step(900);
    chk(ev_cnt == n0, "R3", "one-pass glitch ignored", ev_cnt - n0, 0);
    chk(col_n == '0, "R8", "idle after glitch", int'(col_n), 0);
  endtask

  task automatic t_same_pass;
    int n0;
    n0 = ev_cnt;
    keys[5][1] = 1'b1; keys[0][7] = 1'b1; keys[1][4] = 1'b1; keys[6][4] = 1'b1;
    step(800);
    chk(ev_cnt == n0 + 4, "R6", "same-pass press count", ev_cnt - n0, 4);
    expect_ev(n0 + 0, code(5, 1), 1, "R6");
    expect_ev(n0 + 1, code(1, 4), 1, "R6");
    expect_ev(n0 + 2, code(6, 4), 1, "R6");
    expect_ev(n0 + 3, code(0, 7), 1, "R6");
    keys[5][1] = 1'b0; keys[0][7] = 1'b0; keys[1][4] = 1'b0; keys[6][4] = 1'b0;
    step(800);
    expect_ev(n0 + 4, code(5, 1), 0, "R6");
    expect_ev(n0 + 7, code(0, 7), 0, "R6");
    chk(col_n == '0, "R8", "idle after group release", int'(col_n), 0);
  endtask

  task automatic t_interleave;
    int n0;
    n0 = ev_cnt;
    keys[3][2] = 1'b1; step(700);
    keys[6][8] = 1'b1; step(700);
    keys[3][2] = 1'b0; step(700);
    keys[6][8] = 1'b0; step(800);
    chk(ev_cnt == n0 + 4, "R6", "interleaved count", ev_cnt - n0, 4);
    expect_ev(n0 + 0, code(3, 2), 1, "R6");
    expect_ev(n0 + 1, code(6, 8), 1, "R6");
    expect_ev(n0 + 2, code(3, 2), 0, "R6");
    expect_ev(n0 + 3, code(6, 8), 0, "R6");
  endtask

  task automatic t_backpressure;
    int n0, k0;
    n0 = ev_cnt;
    ev_ready = 1'b0;
    keys[0][0] = 1'b1; keys[3][0] = 1'b1; keys[7][9] = 1'b1;
    step(1000);
    chk(ev_valid == 1'b1, "R7", "valid held while stalled", int'(ev_valid), 1);
    chk(int'(ev_key) == code(0, 0), "R7", "first key held", int'(ev_key), code(0, 0));
    k0 = int'(ev_key);
    step(200);
    chk(int'(ev_key) == k0 && ev_press == 1'b1, "R7", "payload stable", int'(ev_key), k0);
    chk(ev_cnt == n0, "R7", "nothing accepted while stalled", ev_cnt - n0, 0);
    ev_ready = 1'b1;
    step(600);
    chk(ev_cnt == n0 + 3, "R7", "all stalled events delivered", ev_cnt - n0, 3);
    expect_ev(n0 + 0, code(0, 0), 1, "R5");
    expect_ev(n0 + 1, code(3, 0), 1, "R7");
    expect_ev(n0 + 2, code(7, 9), 1, "R5");
    keys[0][0] = 1'b0; keys[3][0] = 1'b0; keys[7][9] = 1'b0;
    step(800);
    expect_ev(n0 + 3, code(0, 0), 0, "R7");
    expect_ev(n0 + 4, code(3, 0), 0, "R7");
    expect_ev(n0 + 5, code(7, 9), 0, "R7");
    chk(col_n == '0, "R8", "idle after corner keys", int'(col_n), 0);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) keys[r] = '0;
    step(5);
    rst_n = 1'b1;
    step(5);
    t_reset();
    t_single();
    t_glitch();
    t_same_pass();
    t_interleave();
    t_backpressure();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule